// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block sits between a CPU's I/O bus and an abstract flash array. Software reaches flash through a small register window. Three address registers (page, row, column) hold a pointer into the array. A data register reads or writes the byte at that pointer, and each completed data access advances the pointer by one.

A control register starts one of three operations: mass erase, page erase or row program. An internal cycle counter times each operation. Both erase commands clear themselves when the counter runs out. A row program ends when software clears its bit, or when its timeout expires.

While an operation runs, the block raises `cpu_wait` only for accesses that touch flash. Memory traffic to other address space, and I/O accesses to the other registers, complete without delay.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0, no operation is active and `cpu_wait` is low.
- R2: Register map on `io_addr`:
  - 0xFB is control. Bit 0 is mass erase, bit 1 is page erase, bit 2 is row program, bit 7 is a read-only busy flag, and the other bits read 0.
  - 0xFC is the page register. Bit 7 is the information-page enable and bits PAGE_W-1:0 hold the page number.
  - 0xFD holds the row in bits ROW_W-1:0.
  - 0xFE holds the 8-bit column.
  - 0xFF is the data port.
  - Unimplemented bits read 0.
- R3: Each completed data-port access adds one to the pointer {page,row,col}. The column wraps from 0xFF to 0x00 and carries into the row. The row wraps from its top value to 0 and carries into the page. The page wraps to 0. The information-enable bit is never changed by this stepping.
- R4: A completed data-port write pulses `fl_wr` for one cycle, with `fl_wdata` equal to the written byte and `fl_addr` equal to the pointer before the step. A completed data-port read pulses `fl_rd` and returns `fl_rdata` on `io_rdata`.
- R5: Writing control bit 0 while idle starts a mass erase. Control bit 0, the busy flag and `fl_mass_ers` stay high for exactly MASS_CYC cycles, starting at the edge that takes the write, and then clear themselves. The duration does not depend on the information-enable bit. `fl_info_en` follows page bit 7.
- R6: Writing control bit 1 while idle starts a page erase. It stays active for exactly PAGE_CYC cycles and then clears itself. When one write sets several command bits, mass erase wins over page erase, and page erase wins over row program.
- R7: During either erase, flash memory accesses (`mem_req` with `mem_flash`) and data-port accesses raise `cpu_wait`. A stalled data-port access neither steps the pointer nor pulses `fl_rd` or `fl_wr`.
- R8: Memory accesses with `mem_flash` low, and I/O accesses to registers other than the data port, never raise `cpu_wait`.
- R9: Writing control bit 2 while idle starts a row program, which works as follows:
  - Flash reads (memory or data port) raise `cpu_wait`.
  - Flash writes and data-port writes proceed.
  - The program ends on a control write with bit 2 clear, or after PROG_CYC cycles.
- R10: While any operation is active, a control write cannot start another operation and cannot change the length of the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_sel | input | 1 | I/O access strobe for this cycle |
| io_wr | input | 1 | I/O access is a write |
| io_addr | input | 8 | I/O register address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mem_req | input | 1 | CPU memory access in this cycle |
| mem_wr | input | 1 | Memory access is a write |
| mem_flash | input | 1 | Memory access targets flash |
| cpu_wait | output | 1 | Stall request to the CPU |
| fl_addr | output | PAGE_W+ROW_W+8 | Flash byte pointer {page,row,col} |
| fl_rdata | input | 8 | Byte read from the array |
| fl_wdata | output | 8 | Byte to program |
| fl_wr | output | 1 | Data-port write strobe |
| fl_rd | output | 1 | Data-port read strobe |
| fl_mass_ers | output | 1 | Mass erase active |
| fl_page_ers | output | 1 | Page erase active (page at `fl_addr`) |
| fl_row_prog | output | 1 | Row program active |
| fl_info_en | output | 1 | Information page enabled |

## Verification
The assertions assume that the CPU makes at most one I/O access per cycle and keeps `io_sel` and `mem_req` stable within a cycle. They also assume that the stepping rule is checked only on cycles where no address register is written, which holds because the port access and a register write share the same strobe. The stimulus drives every input at the falling edge, holds one access for a single rising edge, and then drops the strobe. Protocol rules are therefore never broken, and outputs are sampled at the falling edge after the registers settle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_MASS = 2'd1,
        OP_PAGE = 2'd2,
        OP_PROG = 2'd3
    } op_e;

    localparam logic [7:0] A_CTRL = 8'hFB;
    localparam logic [7:0] A_PAGE = 8'hFC;
    localparam logic [7:0] A_ROW  = 8'hFD;
    localparam logic [7:0] A_COL  = 8'hFE;
    localparam logic [7:0] A_DATA = 8'hFF;

    localparam int CB_MASS = 0;
    localparam int CB_PAGE = 1;
    localparam int CB_PROG = 2;
    localparam int CB_BUSY = 7;
    localparam int COL_W   = 8;

endpackage

// File: rtl/fseq_addr.sv
module fseq_addr
    import fseq_pkg::*;
#(
    parameter int PAGE_W = 7,
    parameter int ROW_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_page,
    input  logic                           ld_row,
    input  logic                           ld_col,
    input  logic                           step,
    input  logic [7:0]                     wdata,
    output logic                           info_en,
    output logic [PAGE_W-1:0]              page,
    output logic [ROW_W-1:0]               row,
    output logic [COL_W-1:0]               col
);
    localparam int AW = PAGE_W + ROW_W + COL_W;

    typedef struct packed {
        logic              info;
        logic [PAGE_W-1:0] page;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } ptr_t;

    ptr_t          st_d, st_q;
    logic [AW-1:0] flat;

    always_comb begin
        st_d = st_q;
        flat = {st_q.page, st_q.row, st_q.col} + AW'(1);
        if (step) begin
            {st_d.page, st_d.row, st_d.col} = flat;
        end else begin
            if (ld_page) begin
                st_d.info = wdata[7];
                st_d.page = wdata[PAGE_W-1:0];
            end
            if (ld_row) st_d.row = wdata[ROW_W-1:0];
            if (ld_col) st_d.col = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign info_en = st_q.info;
    assign page    = st_q.page;
    assign row     = st_q.row;
    assign col     = st_q.col;
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
    import fseq_pkg::*;
#(
    parameter int MASS_CYC = 10_000_000,
    parameter int PAGE_CYC = 500_000,
    parameter int PROG_CYC = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [2:0] cmd,
    output op_e        op
);
    localparam int MAX_EP = (MASS_CYC > PAGE_CYC) ? MASS_CYC : PAGE_CYC;
    localparam int MAXC   = (MAX_EP > PROG_CYC) ? MAX_EP : PROG_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    typedef struct packed {
        op_e           op;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic expired;

    always_comb begin
        st_d    = st_q;
        expired = (st_q.cnt == '0);
        unique case (st_q.op)
            OP_IDLE: begin
                if (cmd_we) begin
                    if (cmd[CB_MASS]) begin
                        st_d.op  = OP_MASS;
                        st_d.cnt = CW'(MASS_CYC - 1);
                    end else if (cmd[CB_PAGE]) begin
                        st_d.op  = OP_PAGE;
                        st_d.cnt = CW'(PAGE_CYC - 1);
                    end else if (cmd[CB_PROG]) begin
                        st_d.op  = OP_PROG;
                        st_d.cnt = CW'(PROG_CYC - 1);
                    end
                end
            end
            OP_PROG: begin
                if ((cmd_we && !cmd[CB_PROG]) || expired) begin
                    st_d.op  = OP_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            default: begin
                if (expired) begin
                    st_d.op  = OP_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{op: OP_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign op = st_q.op;
endmodule

// File: rtl/fseq_wait.sv
module fseq_wait
    import fseq_pkg::*;
(
    input  op_e  op,
    input  logic mem_req,
    input  logic mem_wr,
    input  logic mem_flash,
    input  logic dp_req,
    input  logic dp_wr,
    output logic dp_stall,
    output logic cpu_wait
);
    logic erasing, programming, mem_stall;

    always_comb begin
        erasing     = (op == OP_MASS) || (op == OP_PAGE);
        programming = (op == OP_PROG);
        mem_stall   = mem_req && mem_flash && (erasing || (programming && !mem_wr));
        dp_stall    = dp_req && (erasing || (programming && !dp_wr));
        cpu_wait    = mem_stall || dp_stall;
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import fseq_pkg::*;
#(
    parameter int PAGE_W   = 7,
    parameter int ROW_W    = 3,
    parameter int MASS_CYC = 10_000_000,
    parameter int PAGE_CYC = 500_000,
    parameter int PROG_CYC = 100_000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            io_sel,
    input  logic                            io_wr,
    input  logic [7:0]                      io_addr,
    input  logic [7:0]                      io_wdata,
    output logic [7:0]                      io_rdata,
    input  logic                            mem_req,
    input  logic                            mem_wr,
    input  logic                            mem_flash,
    output logic                            cpu_wait,
    output logic [PAGE_W+ROW_W+COL_W-1:0]   fl_addr,
    input  logic [7:0]                      fl_rdata,
    output logic [7:0]                      fl_wdata,
    output logic                            fl_wr,
    output logic                            fl_rd,
    output logic                            fl_mass_ers,
    output logic                            fl_page_ers,
    output logic                            fl_row_prog,
    output logic                            fl_info_en
);
    logic              reg_we, dp_req, dp_stall, dp_go;
    logic              info;
    logic [PAGE_W-1:0] page;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    op_e               op;

    always_comb begin
        reg_we = io_sel && io_wr;
        dp_req = io_sel && (io_addr == A_DATA);
        dp_go  = dp_req && !dp_stall;
    end

    fseq_addr #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_page (reg_we && (io_addr == A_PAGE)),
        .ld_row  (reg_we && (io_addr == A_ROW)),
        .ld_col  (reg_we && (io_addr == A_COL)),
        .step    (dp_go),
        .wdata   (io_wdata),
        .info_en (info),
        .page    (page),
        .row     (row),
        .col     (col)
    );

    fseq_timer #(.MASS_CYC(MASS_CYC), .PAGE_CYC(PAGE_CYC), .PROG_CYC(PROG_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_we (reg_we && (io_addr == A_CTRL)),
        .cmd    (io_wdata[2:0]),
        .op     (op)
    );

    fseq_wait u_wait (
        .op        (op),
        .mem_req   (mem_req),
        .mem_wr    (mem_wr),
        .mem_flash (mem_flash),
        .dp_req    (dp_req),
        .dp_wr     (io_wr),
        .dp_stall  (dp_stall),
        .cpu_wait  (cpu_wait)
    );

    always_comb begin
        fl_mass_ers = (op == OP_MASS);
        fl_page_ers = (op == OP_PAGE);
        fl_row_prog = (op == OP_PROG);
        fl_info_en  = info;
        fl_addr     = {page, row, col};
        fl_wdata    = io_wdata;
        fl_wr       = dp_go && io_wr;
        fl_rd       = dp_go && !io_wr;
        io_rdata    = '0;
        unique case (io_addr)
            A_CTRL: begin
                io_rdata[CB_MASS] = fl_mass_ers;
                io_rdata[CB_PAGE] = fl_page_ers;
                io_rdata[CB_PROG] = fl_row_prog;
                io_rdata[CB_BUSY] = (op != OP_IDLE);
            end
            A_PAGE: begin
                io_rdata    = 8'(page);
                io_rdata[7] = info;
            end
            A_ROW:   io_rdata = 8'(row);
            A_COL:   io_rdata = col;
            A_DATA:  io_rdata = fl_rdata;
            default: io_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int FA_W     = 18,
    parameter int MASS_CYC = 10_000_000,
    parameter int PAGE_CYC = 500_000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            io_sel,
    input logic            io_wr,
    input logic [7:0]      io_addr,
    input logic            mem_req,
    input logic            mem_wr,
    input logic            mem_flash,
    input logic            cpu_wait,
    input logic [FA_W-1:0] fl_addr,
    input logic            fl_mass_ers,
    input logic            fl_page_ers,
    input logic            fl_row_prog
);
    logic [31:0] mass_run, page_run;
    logic        dp;

    assign dp = io_sel && (io_addr == 8'hFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mass_run <= '0;
            page_run <= '0;
        end else begin
            mass_run <= fl_mass_ers ? mass_run + 32'd1 : '0;
            page_run <= fl_page_ers ? page_run + 32'd1 : '0;
        end
    end

    AST_STEP_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (dp && !cpu_wait) |=> fl_addr == FA_W'($past(fl_addr) + 1'b1)); // R3
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dp && cpu_wait) |=> fl_addr == $past(fl_addr)); // R7
    AST_ERASE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ((fl_mass_ers || fl_page_ers) && mem_req && mem_flash) |-> cpu_wait); // R7
    AST_OTHER_SPACE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mem_req && mem_flash) && !dp) |-> !cpu_wait); // R8
    AST_PROG_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_row_prog && mem_req && mem_flash && !mem_wr) |-> cpu_wait); // R9
    AST_PROG_WRITE_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_row_prog && dp && io_wr && !(mem_req && mem_flash && !mem_wr)) |-> !cpu_wait); // R9
    AST_SINGLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fl_mass_ers, fl_page_ers, fl_row_prog}) <= 1); // R10
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_page_ers || fl_row_prog) |=> !$rose(fl_mass_ers)); // R10
    AST_MASS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_mass_ers) |-> mass_run == 32'(MASS_CYC)); // R5
    AST_PAGE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_page_ers) |-> page_run == 32'(PAGE_CYC)); // R6
endmodule

bind flash_seq_ctrl fseq_chk #(
    .FA_W     (PAGE_W + ROW_W + 8),
    .MASS_CYC (MASS_CYC),
    .PAGE_CYC (PAGE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_sel      (io_sel),
    .io_wr       (io_wr),
    .io_addr     (io_addr),
    .mem_req     (mem_req),
    .mem_wr      (mem_wr),
    .mem_flash   (mem_flash),
    .cpu_wait    (cpu_wait),
    .fl_addr     (fl_addr),
    .fl_mass_ers (fl_mass_ers),
    .fl_page_ers (fl_page_ers),
    .fl_row_prog (fl_row_prog)
);

// File: tb/flash_seq_ctrl_test.sv
module flash_seq_ctrl_test;
    localparam int PW = 2;
    localparam int RW = 3;
    localparam int AW = PW + RW + 8;
    localparam int NADDR = 1 << AW;
    localparam int MC = 48;
    localparam int PC = 32;
    localparam int GC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_sel = 1'b0, io_wr = 1'b0;
    logic [7:0]    io_addr = '0, io_wdata = '0;
    logic [7:0]    io_rdata;
    logic          mem_req = 1'b0, mem_wr = 1'b0, mem_flash = 1'b0;
    logic          cpu_wait;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_rdata, fl_wdata;
    logic          fl_wr, fl_rd, fl_mass_ers, fl_page_ers, fl_row_prog, fl_info_en;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0]    s_rdata, s_wdata;
    logic          s_wait, s_rd, s_wr;
    logic [AW-1:0] s_addr;

    always #2 clk = ~clk;
    assign fl_rdata = 8'(fl_addr) ^ 8'(fl_addr >> 8);

    flash_seq_ctrl #(.PAGE_W(PW), .ROW_W(RW), .MASS_CYC(MC), .PAGE_CYC(PC), .PROG_CYC(GC)) uut (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_req(mem_req), .mem_wr(mem_wr),
        .mem_flash(mem_flash), .cpu_wait(cpu_wait), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
        .fl_wdata(fl_wdata), .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_mass_ers(fl_mass_ers),
        .fl_page_ers(fl_page_ers), .fl_row_prog(fl_row_prog), .fl_info_en(fl_info_en));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_cycle(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_sel = 1'b1; io_wr = wr; io_addr = a; io_wdata = d;
        #1;
        s_rdata = io_rdata; s_wait = cpu_wait; s_rd = fl_rd; s_wr = fl_wr;
        s_addr = fl_addr; s_wdata = fl_wdata;
        @(negedge clk);
        io_sel = 1'b0; io_wr = 1'b0;
    endtask

    task automatic mem_cycle(input logic wr, input logic fl);
        @(negedge clk);
        mem_req = 1'b1; mem_wr = wr; mem_flash = fl;
        #1;
        s_wait = cpu_wait;
        @(negedge clk);
        mem_req = 1'b0; mem_wr = 1'b0; mem_flash = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string req);
        io_cycle(1'b0, a, 8'h00);
        chk(s_rdata == exp && !s_wait, req, {s_wait, s_rdata}, exp);
    endtask

    task automatic run_len(input int which, output int n);
        n = 0;
        while ((which == 0 ? fl_mass_ers : which == 1 ? fl_page_ers : fl_row_prog) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [AW-1:0] flat(input int i);
        int c = i % 256, r = (i / 256) % (1 << RW), p = (i / (256 << RW)) % (1 << PW);
        return AW'((p << (RW + 8)) | (r << 8) | c);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        logic [AW-1:0] ea, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(!cpu_wait && !fl_mass_ers && !fl_page_ers && !fl_row_prog, "R1", cpu_wait, 0);
        rd_reg(8'hFB, 8'h00, "R1 ctrl");
        rd_reg(8'hFC, 8'h00, "R1 page");
        rd_reg(8'hFD, 8'h00, "R1 row");
        rd_reg(8'hFE, 8'h00, "R1 col");

        // R2 readback and masking
        io_cycle(1'b1, 8'hFC, 8'hFF); rd_reg(8'hFC, 8'h83, "R2 page mask");
        chk(fl_info_en == 1'b1, "R2 info pin", fl_info_en, 1);
        io_cycle(1'b1, 8'hFD, 8'hFF); rd_reg(8'hFD, 8'h07, "R2 row mask");
        io_cycle(1'b1, 8'hFE, 8'hA5); rd_reg(8'hFE, 8'hA5, "R2 col");
        io_cycle(1'b1, 8'hFB, 8'h78); rd_reg(8'hFB, 8'h00, "R2 ctrl unused bits");
        chk(fl_addr == AW'(13'h1FA5), "R2 pointer", fl_addr, 13'h1FA5);

        // R3/R4 full read sweep with wrap
        io_cycle(1'b1, 8'hFC, 8'h80);
        io_cycle(1'b1, 8'hFD, 8'h00);
        io_cycle(1'b1, 8'hFE, 8'h00);
        for (int i = 0; i < NADDR + 4; i++) begin
            io_cycle(1'b0, 8'hFF, 8'h00);
            ea = flat(i);
            chk(s_addr == ea, "R3 step", s_addr, ea);
            chk(s_rd && !s_wr && !s_wait && s_rdata == (8'(ea) ^ 8'(ea >> 8)), "R4 read",
                {s_rd, s_rdata}, {1'b1, 8'(ea) ^ 8'(ea >> 8)});
        end
        rd_reg(8'hFC, 8'h80, "R3 info kept page wrapped");
        rd_reg(8'hFE, 8'h04, "R3 col after wrap");

        // R4 writes across the top wrap
        io_cycle(1'b1, 8'hFC, 8'h03);
        io_cycle(1'b1, 8'hFD, 8'h07);
        io_cycle(1'b1, 8'hFE, 8'hF0);
        base = flat(NADDR - 16);
        for (int i = 0; i < 32; i++) begin
            io_cycle(1'b1, 8'hFF, 8'(i * 7 + 3));
            ea = AW'(base + AW'(i));
            chk(s_wr && !s_rd && s_addr == ea && s_wdata == 8'(i * 7 + 3), "R4 write",
                {s_wr, s_addr}, {1'b1, ea});
        end

        // R5 mass erase, info off then on
        io_cycle(1'b1, 8'hFC, 8'h00);
        io_cycle(1'b1, 8'hFB, 8'h01);
        chk(!fl_info_en, "R5 info off", fl_info_en, 0);
        run_len(0, n);
        chk(n == MC, "R5 duration info off", n, MC);
        rd_reg(8'hFB, 8'h00, "R5 self-clear");
        io_cycle(1'b1, 8'hFC, 8'h80);
        io_cycle(1'b1, 8'hFB, 8'h01);
        chk(fl_info_en, "R5 info on", fl_info_en, 1);
        run_len(0, n);
        chk(n == MC, "R5 duration info on", n, MC);

        // R6 page erase duration, priority
        io_cycle(1'b1, 8'hFB, 8'h02);
        run_len(1, n);
        chk(n == PC, "R6 duration", n, PC);
        rd_reg(8'hFB, 8'h00, "R6 self-clear");
        io_cycle(1'b1, 8'hFB, 8'h07);
        chk(fl_mass_ers && !fl_page_ers && !fl_row_prog, "R6 priority mass",
            {fl_mass_ers, fl_page_ers, fl_row_prog}, 3'b100);
        run_len(0, n);
        io_cycle(1'b1, 8'hFB, 8'h06);
        chk(fl_page_ers && !fl_row_prog, "R6 priority page", {fl_page_ers, fl_row_prog}, 2'b10);
        run_len(1, n);

        // R7/R8 stalls during page erase
        io_cycle(1'b1, 8'hFE, 8'h40);
        io_cycle(1'b1, 8'hFB, 8'h02);
        mem_cycle(1'b0, 1'b1); chk(s_wait, "R7 mem read", s_wait, 1);
        mem_cycle(1'b1, 1'b1); chk(s_wait, "R7 mem write", s_wait, 1);
        io_cycle(1'b0, 8'hFF, 8'h00);
        chk(s_wait && !s_rd, "R7 dport read stalled", {s_wait, s_rd}, 2'b10);
        io_cycle(1'b1, 8'hFF, 8'h55);
        chk(s_wait && !s_wr, "R7 dport write stalled", {s_wait, s_wr}, 2'b10);
        rd_reg(8'hFE, 8'h40, "R7 pointer held");
        mem_cycle(1'b0, 1'b0); chk(!s_wait, "R8 other memory", s_wait, 0);
        rd_reg(8'hFB, 8'h82, "R8 ctrl read no wait");
        run_len(1, n);

        // R10 command ignored while busy, duration unchanged
        io_cycle(1'b1, 8'hFB, 8'h02);
        io_cycle(1'b1, 8'hFB, 8'h01);
        chk(!fl_mass_ers && fl_page_ers, "R10 no mass start", {fl_mass_ers, fl_page_ers}, 2'b01);
        run_len(1, n);
        chk(n == PC - 2, "R10 page length kept", n, PC - 2);

        // R9 row program
        io_cycle(1'b1, 8'hFE, 8'h10);
        io_cycle(1'b1, 8'hFB, 8'h04);
        rd_reg(8'hFB, 8'h84, "R9 ctrl busy");
        mem_cycle(1'b0, 1'b1); chk(s_wait, "R9 mem read stalls", s_wait, 1);
        mem_cycle(1'b1, 1'b1); chk(!s_wait, "R9 mem write flows", s_wait, 0);
        io_cycle(1'b1, 8'hFF, 8'h3C);
        chk(!s_wait && s_wr && 8'(s_addr) == 8'h10, "R9 dport write", {s_wait, s_wr}, 2'b01);
        io_cycle(1'b0, 8'hFF, 8'h00);
        chk(s_wait && !s_rd, "R9 dport read stalls", {s_wait, s_rd}, 2'b10);
        io_cycle(1'b1, 8'hFB, 8'h05);
        chk(fl_row_prog && !fl_mass_ers, "R10 ignored during program", {fl_row_prog, fl_mass_ers}, 2'b10);
        io_cycle(1'b1, 8'hFB, 8'h00);
        chk(!fl_row_prog, "R9 completion", fl_row_prog, 0);
        rd_reg(8'hFE, 8'h11, "R9 pointer stepped once");
        io_cycle(1'b1, 8'hFB, 8'h04);
        run_len(2, n);
        chk(n == GC, "R9 timeout", n, GC);
        rd_reg(8'hFB, 8'h00, "R9 cleared after timeout");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule